// File: doc/BRIEF.md
# Time-Tagged Pin Event Capture

The block watches a small group of digital input pins and records when they change. Once per sampling window it compares each pin against the value seen in the previous window. Each pin has its own enable and its own edge selection: rising, falling or either. Every pin that shows a selected change in that window contributes one bit to an event mask. The mask is stored together with the current value of a free-running time-tag counter, which advances on an external tick pulse.

Entries are delivered through one holding register that software reads directly. A small FIFO behind it holds later entries. When nothing is waiting, a new entry lands in the holding register and the FIFO stays empty. A read strobe retires the holding entry and refills it from the FIFO on the same clock edge. The holding-valid output serves as the event flag.

The sampling window length is independent of the tick period. With the default window of nine clocks and a tick every eight clocks, the tags of entries from successive windows now and then jump by two.

Top module: `evtag_capture`

## Requirements
- R1: After reset `holdValid`, `fifoFull` and `overflow` are 0, the time-tag counter is 0 and the remembered previous sample of every pin is 0.
- R2: Pins are sampled on clock edges WINDOW, 2·WINDOW, 3·WINDOW, … counted after reset release (default WINDOW = 9). The time-tag counter increments on every edge where `timerTick` is 1. An entry's tag is the counter value held just before its sampling edge.
- R3: `edgeMode[2i+1:2i]` selects the edges for pin i. Bit 2i enables rising (previous sample 0, current 1). Bit 2i+1 enables falling (previous 1, current 0). The value 00 records nothing.
- R4: A pin whose `pinEnable` bit is 0 never sets its mask bit, whatever it does.
- R5: All selected edges found in one sampling edge form a single entry with one tag. Bit i of `holdMask` is pin i.
- R6: An entry that arrives while the holding register and the FIFO are both empty goes into the holding register, and the FIFO stays empty.
- R7: An entry that arrives while the holding register is valid is appended to the FIFO. Entries leave in arrival order, and entries from different windows are separate.
- R8: A read strobe while `holdValid` is 1 loads the oldest FIFO entry into the holding register on that edge, or clears `holdValid` if the FIFO is empty. A read strobe while `holdValid` is 0 has no effect.
- R9: `fifoFull` is 1 when the FIFO holds DEPTH (default 7) entries. An entry that arrives with the FIFO full, the holding register valid and no read is discarded. The discard sets `overflow`, which stays 1 until reset, and the stored entries are unchanged.
- R10: A read strobe on the same edge as a new entry loses nothing. If the FIFO is empty the new entry becomes the holding entry; otherwise the FIFO head moves up and the new entry is appended.
- R11: With a tick every 8 clocks and WINDOW = 9, the tags of entries from consecutive windows differ by 1. Exactly one difference in any 9-window span is 2, because one counter value is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | PINS | Monitored pins |
| pinEnable | input | PINS | Per-pin capture enable |
| edgeMode | input | 2·PINS | Per-pin edge selection (bit 0 rise, bit 1 fall) |
| timerTick | input | 1 | Advance the time-tag counter |
| readStrobe | input | 1 | Retire the holding entry |
| holdValid | output | 1 | Holding register holds an entry (event flag) |
| holdMask | output | PINS | Event mask of the holding entry |
| holdTag | output | TAG_W | Time tag of the holding entry |
| fifoFull | output | 1 | FIFO holds DEPTH entries |
| overflow | output | 1 | Sticky: an entry was discarded |

## Verification
Pin changes on the same and on different windows are aimed at the merging rule. A design that sampled every cycle would split a simultaneous change into several entries, or give two entries the same tag. Reads that land exactly on a sampling edge, with the FIFO empty and then non-empty, would expose a design that drops the arriving entry or pops twice. The FIFO is filled to one entry past capacity: a wrong design would overwrite the oldest entry or flag overflow one entry too early. A nine-window run checks that the tag sequence skips exactly one value, which a design that tagged with a window count or ran the counter off its own clock division would miss.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  // Strobes from the control unit to the datapath, valid for one edge.
  typedef struct packed {
    logic sample;     // end of sampling window: latch pins
    logic loadNew;    // holding register <= freshly formed entry
    logic loadHead;   // holding register <= FIFO head
    logic clearHold;  // holding register becomes empty
    logic push;       // append fresh entry to FIFO
    logic pop;        // drop FIFO head
    logic setOvf;     // fresh entry discarded
  } ctrl_t;
endpackage

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PW-1:0]    rdPtr, wrPtr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (push && wrPtr == PW'(s)) slot[s] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign head  = slot[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R9: the control never appends to a full FIFO unless it pops too
  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop) |-> !push);
  // R8: nothing is popped from an empty FIFO
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !pop);
  // R7: an append without a pop grows the occupancy by one
  p_count_up_r7: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (count == $past(count) + CW'(1)));
endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
  import evcap_pkg::*;
#(
  parameter int WINDOW = 9
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  anyEdge,
  input  logic  holdValid,
  input  logic  fifoEmpty,
  input  logic  fifoFull,
  input  logic  readStrobe,
  output ctrl_t ctl
);
  localparam int WCW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [WCW-1:0] winCnt;
  logic           sampleNow, arrive, doRead;

  always_ff @(posedge clk) begin
    if (!rstN) winCnt <= '0;
    else if (sampleNow) winCnt <= '0;
    else winCnt <= winCnt + WCW'(1);
  end

  assign sampleNow = (winCnt == WCW'(WINDOW - 1));
  assign arrive    = sampleNow && anyEdge;
  assign doRead    = readStrobe && holdValid;

  always_comb begin
    ctl        = '0;
    ctl.sample = sampleNow;
    if (doRead) begin
      if (!fifoEmpty) begin
        ctl.loadHead = 1'b1;
        ctl.pop      = 1'b1;
        ctl.push     = arrive;
      end else if (arrive) begin
        ctl.loadNew  = 1'b1;
      end else begin
        ctl.clearHold = 1'b1;
      end
    end else if (arrive) begin
      if (!holdValid)     ctl.loadNew = 1'b1;
      else if (!fifoFull) ctl.push    = 1'b1;
      else                ctl.setOvf  = 1'b1;
    end
  end

  // R6: a fresh entry only goes straight to holding when the FIFO is empty
  p_loadnew_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadNew |-> fifoEmpty);
  // R9: entries are discarded only when both stores are full and no read
  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setOvf |-> (fifoFull && holdValid && !readStrobe));

  generate
    if (WINDOW > 1) begin : g_gap
      // R2: sampling edges are never adjacent
      p_window_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
        ctl.sample |=> !ctl.sample);
    end
  endgenerate
endmodule

// File: rtl/evcap_dp.sv
module evcap_dp
  import evcap_pkg::*;
#(
  parameter int PINS  = 4,
  parameter int TAG_W = 16,
  parameter int DEPTH = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [PINS-1:0]   pinIn,
  input  logic [PINS-1:0]   pinEnable,
  input  logic [2*PINS-1:0] edgeMode,
  input  logic              timerTick,
  output logic              anyEdge,
  output logic              holdValid,
  output logic [PINS-1:0]   holdMask,
  output logic [TAG_W-1:0]  holdTag,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              overflow
);
  localparam int EW = PINS + TAG_W;

  logic [TAG_W-1:0] timer;
  logic [PINS-1:0]  prevSample, edgeMask;
  logic [EW-1:0]    freshEntry, fifoHead;

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (timerTick) timer <= timer + TAG_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevSample <= '0;
    else if (ctl.sample) prevSample <= pinIn;
  end

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic rise, fall;
      assign rise = pinIn[i] & ~prevSample[i];
      assign fall = ~pinIn[i] & prevSample[i];
      assign edgeMask[i] = pinEnable[i] &
                           ((edgeMode[2*i] & rise) | (edgeMode[2*i+1] & fall));
    end
  endgenerate

  assign anyEdge    = |edgeMask;
  assign freshEntry = {edgeMask, timer};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdMask  <= '0;
      holdTag   <= '0;
    end else if (ctl.loadNew) begin
      holdValid <= 1'b1;
      {holdMask, holdTag} <= freshEntry;
    end else if (ctl.loadHead) begin
      holdValid <= 1'b1;
      {holdMask, holdTag} <= fifoHead;
    end else if (ctl.clearHold) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else if (ctl.setOvf) overflow <= 1'b1;
  end

  evcap_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rstN (rstN),
    .push (ctl.push),
    .pop  (ctl.pop),
    .din  (freshEntry),
    .head (fifoHead),
    .empty(fifoEmpty),
    .full (fifoFull)
  );

  // R6: the FIFO is never occupied behind an empty holding register
  p_fifo_behind_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEmpty |-> holdValid);
  // R9: the overflow flag is sticky until reset
  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

// File: rtl/evtag_capture.sv
module evtag_capture
  import evcap_pkg::*;
#(
  parameter int PINS   = 4,
  parameter int TAG_W  = 16,
  parameter int DEPTH  = 7,
  parameter int WINDOW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic [PINS-1:0]   pinEnable,
  input  logic [2*PINS-1:0] edgeMode,
  input  logic              timerTick,
  input  logic              readStrobe,
  output logic              holdValid,
  output logic [PINS-1:0]   holdMask,
  output logic [TAG_W-1:0]  holdTag,
  output logic              fifoFull,
  output logic              overflow
);
  ctrl_t ctl;
  logic  anyEdge, fifoEmpty;

  evcap_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyEdge   (anyEdge),
    .holdValid (holdValid),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .readStrobe(readStrobe),
    .ctl       (ctl)
  );

  evcap_dp #(.PINS(PINS), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pinIn    (pinIn),
    .pinEnable(pinEnable),
    .edgeMode (edgeMode),
    .timerTick(timerTick),
    .anyEdge  (anyEdge),
    .holdValid(holdValid),
    .holdMask (holdMask),
    .holdTag  (holdTag),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull),
    .overflow (overflow)
  );
endmodule

// File: tb/sim_evtag_capture.sv
`timescale 1ns/1ps
module sim_evtag_capture;
  localparam int W = 9;

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  pinIn = '0;
  logic [3:0]  pinEnable = 4'b1111;
  logic [7:0]  edgeMode = 8'b11_11_10_01; // pin0 rise, pin1 fall, pin2/3 both
  logic        timerTick;
  logic        readStrobe = 0;
  logic        holdValid, fifoFull, overflow;
  logic [3:0]  holdMask;
  logic [15:0] holdTag;

  int errs = 0, checks = 0;
  int edgeNum, sampCount, tickPh;
  logic [15:0] mTimer, sampTag;

  always #5 clk = ~clk;

  evtag_capture u0 (.clk(clk), .rstN(rstN), .pinIn(pinIn), .pinEnable(pinEnable),
    .edgeMode(edgeMode), .timerTick(timerTick), .readStrobe(readStrobe),
    .holdValid(holdValid), .holdMask(holdMask), .holdTag(holdTag),
    .fifoFull(fifoFull), .overflow(overflow));

  // tick every 8 clocks
  always @(negedge clk) begin
    if (!rstN) begin tickPh <= 0; timerTick <= 0; end
    else begin timerTick <= (tickPh == 7); tickPh <= (tickPh + 1) % 8; end
  end

  // requirement model of window phase and tag counter (R2)
  always @(posedge clk) begin
    if (!rstN) begin edgeNum <= 0; mTimer <= 0; sampCount <= 0; sampTag <= 0; end
    else begin
      edgeNum <= edgeNum + 1;
      if ((edgeNum + 1) % W == 0) begin sampTag <= mTimer; sampCount <= sampCount + 1; end
      if (timerTick) mTimer <= mTimer + 16'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitSample(output logic [15:0] tag);
    int s = sampCount;
    do @(negedge clk); while (sampCount == s);
    tag = sampTag;
  endtask

  task automatic doRead();
    readStrobe = 1;
    @(negedge clk);
    readStrobe = 0;
  endtask

  task automatic t_reset();
    logic [15:0] t;
    chk("R1 holdValid", holdValid, 0);
    chk("R1 fifoFull", fifoFull, 0);
    chk("R1 overflow", overflow, 0);
    waitSample(t);
    chk("R1 no event with idle pins", holdValid, 0);
  endtask

  task automatic t_single();
    logic [15:0] t;
    pinIn[0] = 1;
    waitSample(t);
    chk("R2 holdValid", holdValid, 1);
    chk("R3 rise mask", holdMask, 4'b0001);
    chk("R2 tag", holdTag, t);
    doRead();
    chk("R6 fifo stayed empty", holdValid, 0);
  endtask

  task automatic t_modes();
    logic [15:0] t;
    pinIn[0] = 0; waitSample(t);
    chk("R3 fall ignored on rise-only", holdValid, 0);
    pinIn[1] = 1; waitSample(t);
    chk("R3 rise ignored on fall-only", holdValid, 0);
    pinIn[1] = 0; waitSample(t);
    chk("R3 fall mask", holdMask, 4'b0010);
    chk("R3 fall tag", holdTag, t);
    doRead();
    pinIn[2] = 1; waitSample(t);
    chk("R3 both rise", holdMask, 4'b0100);
    doRead();
    pinIn[2] = 0; waitSample(t);
    chk("R3 both fall", holdMask, 4'b0100);
    doRead();
    edgeMode[7:6] = 2'b00;
    pinIn[3] = 1; waitSample(t);
    chk("R3 mode 00 records nothing", holdValid, 0);
    pinIn[3] = 0; waitSample(t);
    edgeMode[7:6] = 2'b11;
  endtask

  task automatic t_disable();
    logic [15:0] t;
    pinEnable[3] = 0;
    pinIn[3] = 1; waitSample(t);
    chk("R4 disabled rise", holdValid, 0);
    pinIn[3] = 0; waitSample(t);
    chk("R4 disabled fall", holdValid, 0);
    pinEnable[3] = 1;
  endtask

  task automatic t_simul();
    logic [15:0] t;
    pinIn = 4'b1101; waitSample(t);
    chk("R5 merged mask", holdMask, 4'b1101);
    chk("R5 single tag", holdTag, t);
    doRead();
    chk("R5 one entry only", holdValid, 0);
    pinIn = 4'b0000; waitSample(t);
    chk("R5 merged falls", holdMask, 4'b1100);
    doRead();
  endtask

  task automatic t_order();
    logic [15:0] t1, t2, t3;
    pinIn[2] = 1; waitSample(t1);
    pinIn[2] = 0; waitSample(t2);
    pinIn[2] = 1; waitSample(t3);
    chk("R7 oldest in holding", holdTag, t1);
    chk("R7 tags apart", (t2 > t1) && (t3 > t2), 1);
    doRead();
    chk("R8 pop second", holdTag, t2);
    doRead();
    chk("R8 pop third", holdTag, t3);
    doRead();
    chk("R8 empty after drain", holdValid, 0);
    pinIn[2] = 0; waitSample(t1);
    doRead();
  endtask

  task automatic t_skip();
    logic [15:0] t, dut [9];
    int twos = 0, bad = 0;
    for (int j = 0; j < 9; j++) begin
      pinIn[3] = ~pinIn[3];
      waitSample(t);
      if (j == 4) begin dut[0] = holdTag; doRead(); end
    end
    chk("R9 full at depth", fifoFull, 1);
    chk("R9 no overflow at capacity", overflow, 0);
    for (int j = 1; j < 9; j++) begin dut[j] = holdTag; doRead(); end
    chk("R8 drained", holdValid, 0);
    for (int j = 1; j < 9; j++) begin
      if (dut[j] - dut[j-1] == 16'd2) twos++;
      else if (dut[j] - dut[j-1] != 16'd1) bad++;
    end
    chk("R11 tag steps 1 or 2", bad, 0);
    chk("R11 exactly one skipped tag", twos, 1);
  endtask

  task automatic t_overflow();
    logic [15:0] tg [9];
    for (int j = 0; j < 9; j++) begin
      pinIn[2] = ~pinIn[2];
      waitSample(tg[j]);
      if (j == 7) begin
        chk("R9 full", fifoFull, 1);
        chk("R9 not yet overflow", overflow, 0);
      end
    end
    chk("R9 overflow set", overflow, 1);
    chk("R9 holding unchanged", holdTag, tg[0]);
    for (int j = 0; j < 8; j++) begin
      chk("R9 kept entry order", holdTag, tg[j]);
      doRead();
      if (j == 0) chk("R9 full cleared", fifoFull, 0);
    end
    chk("R9 dropped entry absent", holdValid, 0);
    chk("R9 overflow sticky", overflow, 1);
  endtask

  task automatic t_idle_read();
    logic [15:0] t;
    doRead();
    chk("R8 idle read no effect", holdValid, 0);
    pinIn[2] = ~pinIn[2]; waitSample(t);
    chk("R8 next entry intact", holdTag, t);
    doRead();
  endtask

  task automatic t_collide();
    logic [15:0] t0, t1, t2;
    // holding full, FIFO empty, read on the sampling edge
    pinIn[2] = ~pinIn[2]; waitSample(t0);
    pinIn[2] = ~pinIn[2];
    for (int k = 0; k < 8; k++) @(negedge clk);
    doRead();
    t1 = sampTag;
    chk("R10 new entry to holding", holdValid, 1);
    chk("R10 new entry tag", holdTag, t1);
    doRead();
    chk("R10 single entry", holdValid, 0);
    // holding + one FIFO entry, read on the sampling edge
    pinIn[2] = ~pinIn[2]; waitSample(t0);
    pinIn[2] = ~pinIn[2]; waitSample(t1);
    pinIn[2] = ~pinIn[2];
    for (int k = 0; k < 8; k++) @(negedge clk);
    doRead();
    t2 = sampTag;
    chk("R10 head moved up", holdTag, t1);
    doRead();
    chk("R10 new entry appended", holdTag, t2);
    doRead();
    chk("R10 drained", holdValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_single();
    t_modes();
    t_disable();
    t_simul();
    t_order();
    t_skip();
    t_idle_read();
    t_collide();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule